// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's control path. When the core raises a take strobe, the sequencer decides whether to enter an exception handler, an interrupt handler, or nothing. When a pending exception and a pending interrupt arrive together, the exception is chosen. While the status word's block bit is set, most exceptions are turned into a reset entry. An interrupt under the block bit is accepted only when the core is asleep.

On entry the block saves the current status, program counter and stack register into shadow registers. If the interrupted instruction is in a branch delay slot, the saved program counter is moved back so that the branch runs again. The block then forces the privileged status bits and picks the handler address from the vector base or a fixed reset address. It also records the event code in an exception code register or an interrupt code register.

For interrupts, an external priority controller is given the current 4-bit mask level and returns a vector with a valid flag. Every result is registered. The core loads the new state when it sees the one-cycle redirect pulse.

Top module: `exc_entry_seq`

## Requirements
- R1: When an exception is pending (`exc_valid_i`=1), it is taken even if an interrupt is also pending, and `intevt_o` keeps its value.
- R2: While status bit 28 (block) is set, any exception code other than 0x1E0 is entered as code 0x000, with the reset treatment of R7 and no trap adjustment of R9. Code 0x1E0 is entered unchanged.
- R3: While status bit 28 is set, a pending interrupt with no exception is ignored unless `sleep_i`=1. Every entry pulses `sleep_clr_o` for one cycle.
- R4: `irq_level_o` always equals status bits 7:4. An interrupt with `irq_vec_valid_i`=0 causes no entry and leaves every output unchanged.
- R5: On entry, `ssr_o` takes `sr_i`, `sgr_o` takes `r15_i`, and `sr_o` is `sr_i` with bits 30 (privileged mode), 29 (register bank) and 28 (block) set.
- R6: If either bit of `dslot_i` is set on entry, the saved PC is `pc_i`-2 and `dslot_clr_o` pulses for one cycle. Otherwise the saved PC is `pc_i`.
- R7: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 to 0xF, and set the new PC to 0xA0000000.
- R8: Exception codes 0x040 and 0x060 set the new PC to VBR+0x400. Every other exception code not covered by R7 sets it to VBR+0x100.
- R9: Exception code 0x160 adds 2 to the saved PC, after any delay-slot adjustment.
- R10: An exception writes its effective code to `expevt_o`. An interrupt writes the vector to `intevt_o`, sets the new PC to VBR+0x600, and leaves `expevt_o` unchanged.
- R11: The outputs change only in the cycle after a take strobe that produces an entry. `redirect_o` is high in exactly that cycle. Without a take, no entry occurs and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Core asks for an entry decision this cycle |
| exc_valid_i | input | 1 | An exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_pend_i | input | 1 | An interrupt is pending |
| irq_level_o | output | 4 | Mask level given to the priority controller |
| irq_vec_valid_i | input | 1 | Controller has an acceptable vector |
| irq_vec_i | input | 12 | Vector from the controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| r15_i | input | 32 | Current stack register |
| vbr_i | input | 32 | Vector base |
| dslot_i | input | 2 | Delay-slot flags (unconditional, conditional) |
| sleep_i | input | 1 | Core is sleeping |
| redirect_o | output | 1 | One-cycle pulse: an entry occurred |
| sr_o | output | 32 | New status word |
| pc_o | output | 32 | Handler address |
| ssr_o | output | 32 | Saved status |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack register |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt vector |
| dslot_clr_o | output | 1 | Pulse: clear delay-slot flags |
| sleep_clr_o | output | 1 | Pulse: clear sleep flag |

## Verification
The bench applies ordinary, TLB-miss, reset-class and trap exception codes. This checks that each code is routed to its own handler address and status treatment. It repeats the trap and an ordinary code with each delay-slot flag set, to separate the rewind from the trap advance. It also applies exceptions and interrupts together, and interrupts with and without a valid vector, to show exception priority and vector gating. Finally it applies the same codes with the block bit set, with sleep on and off, which tells the reset conversion and interrupt masking apart from the normal paths.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int WORD_W = 32;
  localparam int CODE_W = 12;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_EXC  = 2'd1,
    ENT_IRQ  = 2'd2
  } ent_kind_e;

  localparam logic [CODE_W-1:0] EV_POWER   = 12'h000;
  localparam logic [CODE_W-1:0] EV_MANUAL  = 12'h020;
  localparam logic [CODE_W-1:0] EV_TLB_RD  = 12'h040;
  localparam logic [CODE_W-1:0] EV_TLB_WR  = 12'h060;
  localparam logic [CODE_W-1:0] EV_MULTI   = 12'h140;
  localparam logic [CODE_W-1:0] EV_TRAP    = 12'h160;
  localparam logic [CODE_W-1:0] EV_BL_PASS = 12'h1E0;

  localparam logic [WORD_W-1:0] RESET_PC = 32'hA000_0000;
  localparam logic [WORD_W-1:0] OFS_GEN  = 32'h0000_0100;
  localparam logic [WORD_W-1:0] OFS_TLB  = 32'h0000_0400;
  localparam logic [WORD_W-1:0] OFS_IRQ  = 32'h0000_0600;

  function automatic logic is_reset_class(input logic [CODE_W-1:0] c);
    return (c == EV_POWER) || (c == EV_MANUAL) || (c == EV_MULTI);
  endfunction

  function automatic logic is_tlb_miss(input logic [CODE_W-1:0] c);
    return (c == EV_TLB_RD) || (c == EV_TLB_WR);
  endfunction

  function automatic logic [WORD_W-1:0] handler_addr(
    input ent_kind_e k, input logic [CODE_W-1:0] c, input logic [WORD_W-1:0] vbr);
    logic [WORD_W-1:0] a;
    if (k == ENT_IRQ)          a = vbr + OFS_IRQ;
    else if (is_reset_class(c)) a = RESET_PC;
    else if (is_tlb_miss(c))   a = vbr + OFS_TLB;
    else                       a = vbr + OFS_GEN;
    return a;
  endfunction

  function automatic logic [WORD_W-1:0] saved_pc(
    input ent_kind_e k, input logic [CODE_W-1:0] c, input logic [WORD_W-1:0] pc,
    input logic in_slot);
    logic [WORD_W-1:0] s;
    s = in_slot ? (pc - 32'd2) : pc;
    if (k == ENT_EXC && c == EV_TRAP) s = s + 32'd2;
    return s;
  endfunction

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
  import exc_entry_pkg::*;
#(
  parameter int BL_BIT    = 28,
  parameter int IMASK_LO  = 4
) (
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic              irq_pend_i,
  input  logic              irq_vec_valid_i,
  input  logic [CODE_W-1:0] irq_vec_i,
  input  logic [WORD_W-1:0] sr_i,
  input  logic              sleep_i,
  output ent_kind_e         kind_o,
  output logic [CODE_W-1:0] code_o,
  output logic [3:0]        level_o
);
  logic blocked;
  assign blocked = sr_i[BL_BIT];
  assign level_o = sr_i[IMASK_LO +: 4];

  always_comb begin
    kind_o = ENT_NONE;
    code_o = exc_code_i;
    if (exc_valid_i) begin
      kind_o = ENT_EXC;
      if (blocked && exc_code_i != EV_BL_PASS) code_o = EV_POWER;
    end else if (irq_pend_i && (!blocked || sleep_i) && irq_vec_valid_i) begin
      kind_o = ENT_IRQ;
      code_o = irq_vec_i;
    end
    if (!take_i) kind_o = ENT_NONE;
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter int MD_BIT   = 30,
  parameter int RB_BIT   = 29,
  parameter int BL_BIT   = 28,
  parameter int FD_BIT   = 15,
  parameter int IMASK_LO = 4
) (
  input  ent_kind_e         kind_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [WORD_W-1:0] sr_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] vbr_i,
  input  logic              in_slot_i,
  output logic [WORD_W-1:0] nxt_sr_o,
  output logic [WORD_W-1:0] nxt_pc_o,
  output logic [WORD_W-1:0] nxt_spc_o
);
  always_comb begin
    nxt_sr_o = sr_i;
    nxt_sr_o[MD_BIT] = 1'b1;
    nxt_sr_o[RB_BIT] = 1'b1;
    nxt_sr_o[BL_BIT] = 1'b1;
    if (kind_i == ENT_EXC && is_reset_class(code_i)) begin
      nxt_sr_o[FD_BIT] = 1'b0;
      nxt_sr_o[IMASK_LO +: 4] = 4'hF;
    end
  end

  assign nxt_pc_o  = handler_addr(kind_i, code_i, vbr_i);
  assign nxt_spc_o = saved_pc(kind_i, code_i, pc_i, in_slot_i);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int MD_BIT   = 30,
  parameter int RB_BIT   = 29,
  parameter int BL_BIT   = 28,
  parameter int FD_BIT   = 15,
  parameter int IMASK_LO = 4,
  parameter int SLOT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              exc_valid_i,
  input  logic [11:0]       exc_code_i,
  input  logic              irq_pend_i,
  output logic [3:0]        irq_level_o,
  input  logic              irq_vec_valid_i,
  input  logic [11:0]       irq_vec_i,
  input  logic [31:0]       sr_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       r15_i,
  input  logic [31:0]       vbr_i,
  input  logic [SLOT_W-1:0] dslot_i,
  input  logic              sleep_i,
  output logic              redirect_o,
  output logic [31:0]       sr_o,
  output logic [31:0]       pc_o,
  output logic [31:0]       ssr_o,
  output logic [31:0]       spc_o,
  output logic [31:0]       sgr_o,
  output logic [11:0]       expevt_o,
  output logic [11:0]       intevt_o,
  output logic              dslot_clr_o,
  output logic              sleep_clr_o
);
  ent_kind_e         kind_w;
  logic [CODE_W-1:0] code_w;
  logic [WORD_W-1:0] nxt_sr_w, nxt_pc_w, nxt_spc_w;
  logic              in_slot_w;
  logic              entry_w;
  logic              irq_taken_q;
  logic              exc_taken_q;

  assign in_slot_w = |dslot_i;
  assign entry_w   = (kind_w != ENT_NONE);

  exc_entry_arb #(.BL_BIT(BL_BIT), .IMASK_LO(IMASK_LO)) u_arb (
    .take_i          (take_i),
    .exc_valid_i     (exc_valid_i),
    .exc_code_i      (exc_code_i),
    .irq_pend_i      (irq_pend_i),
    .irq_vec_valid_i (irq_vec_valid_i),
    .irq_vec_i       (irq_vec_i),
    .sr_i            (sr_i),
    .sleep_i         (sleep_i),
    .kind_o          (kind_w),
    .code_o          (code_w),
    .level_o         (irq_level_o)
  );

  exc_entry_calc #(
    .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT),
    .FD_BIT(FD_BIT), .IMASK_LO(IMASK_LO)
  ) u_calc (
    .kind_i    (kind_w),
    .code_i    (code_w),
    .sr_i      (sr_i),
    .pc_i      (pc_i),
    .vbr_i     (vbr_i),
    .in_slot_i (in_slot_w),
    .nxt_sr_o  (nxt_sr_w),
    .nxt_pc_o  (nxt_pc_w),
    .nxt_spc_o (nxt_spc_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o  <= 1'b0;
      dslot_clr_o <= 1'b0;
      sleep_clr_o <= 1'b0;
      irq_taken_q <= 1'b0;
      exc_taken_q <= 1'b0;
    end else begin
      redirect_o  <= entry_w;
      dslot_clr_o <= entry_w && in_slot_w;
      sleep_clr_o <= entry_w;
      if (entry_w) begin
        irq_taken_q <= (kind_w == ENT_IRQ);
        exc_taken_q <= (kind_w == ENT_EXC);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o     <= '0;
      pc_o     <= '0;
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
    end else if (entry_w) begin
      sr_o  <= nxt_sr_w;
      pc_o  <= nxt_pc_w;
      ssr_o <= sr_i;
      spc_o <= nxt_spc_w;
      sgr_o <= r15_i;
      if (kind_w == ENT_EXC) expevt_o <= code_w;
      else                   intevt_o <= code_w;
    end
  end
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int MD_BIT   = 30,
  parameter int RB_BIT   = 29,
  parameter int BL_BIT   = 28,
  parameter int FD_BIT   = 15,
  parameter int IMASK_LO = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        take_i,
  input logic        exc_valid_i,
  input logic        irq_pend_i,
  input logic        sleep_i,
  input logic [31:0] sr_i,
  input logic [31:0] vbr_i,
  input logic        redirect_o,
  input logic [31:0] sr_o,
  input logic [31:0] pc_o,
  input logic [31:0] ssr_o,
  input logic [11:0] expevt_o,
  input logic        irq_taken_q,
  input logic        exc_taken_q
);
  // R11
  redirect_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(take_i));

  // R5
  priv_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (sr_o[MD_BIT] && sr_o[RB_BIT] && sr_o[BL_BIT]));

  // R5
  saved_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (ssr_o == $past(sr_i)));

  // R1
  exc_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && irq_taken_q) |-> !$past(exc_valid_i));

  // R3
  blocked_irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(take_i && !exc_valid_i && irq_pend_i && sr_i[BL_BIT] && !sleep_i) |-> !redirect_o);

  // R7
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && exc_taken_q &&
     (expevt_o == 12'h000 || expevt_o == 12'h020 || expevt_o == 12'h140))
    |-> (pc_o == 32'hA000_0000 && sr_o[IMASK_LO +: 4] == 4'hF && !sr_o[FD_BIT]));

  // R10
  irq_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && irq_taken_q) |-> (pc_o == $past(vbr_i) + 32'h600));
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
  .MD_BIT(MD_BIT), .RB_BIT(RB_BIT), .BL_BIT(BL_BIT),
  .FD_BIT(FD_BIT), .IMASK_LO(IMASK_LO)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .take_i      (take_i),
  .exc_valid_i (exc_valid_i),
  .irq_pend_i  (irq_pend_i),
  .sleep_i     (sleep_i),
  .sr_i        (sr_i),
  .vbr_i       (vbr_i),
  .redirect_o  (redirect_o),
  .sr_o        (sr_o),
  .pc_o        (pc_o),
  .ssr_o       (ssr_o),
  .expevt_o    (expevt_o),
  .irq_taken_q (irq_taken_q),
  .exc_taken_q (exc_taken_q)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        take_i = 0, exc_valid_i = 0, irq_pend_i = 0, irq_vec_valid_i = 0, sleep_i = 0;
  logic [11:0] exc_code_i = 0, irq_vec_i = 0;
  logic [31:0] sr_i = 0, pc_i = 0;
  logic [31:0] r15_i = 32'h1234_5678, vbr_i = 32'h8C00_0000;
  logic [1:0]  dslot_i = 0;
  logic [3:0]  irq_level_o;
  logic        redirect_o, dslot_clr_o, sleep_clr_o;
  logic [31:0] sr_o, pc_o, ssr_o, spc_o, sgr_o;
  logic [11:0] expevt_o, intevt_o;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .exc_valid_i(exc_valid_i),
    .exc_code_i(exc_code_i), .irq_pend_i(irq_pend_i), .irq_level_o(irq_level_o),
    .irq_vec_valid_i(irq_vec_valid_i), .irq_vec_i(irq_vec_i), .sr_i(sr_i),
    .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i), .dslot_i(dslot_i), .sleep_i(sleep_i),
    .redirect_o(redirect_o), .sr_o(sr_o), .pc_o(pc_o), .ssr_o(ssr_o), .spc_o(spc_o),
    .sgr_o(sgr_o), .expevt_o(expevt_o), .intevt_o(intevt_o),
    .dslot_clr_o(dslot_clr_o), .sleep_clr_o(sleep_clr_o)
  );

  typedef struct packed {
    logic        exc_v;
    logic [11:0] code;
    logic        irq;
    logic        vval;
    logic [11:0] vec;
    logic [31:0] sr;
    logic [31:0] pc;
    logic [1:0]  ds;
    logic        slp;
    logic        redir;
    logic [31:0] epc;
    logic [31:0] esr;
    logic [31:0] espc;
    logic [11:0] evt;
  } vec_t;

  localparam int N = 17;
  localparam vec_t TBL [N] = '{
    '{1'b1,12'h180,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,12'h180},
    '{1'b1,12'h040,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0400,32'h7000_8030,32'h0C00_1000,12'h040},
    '{1'b1,12'h060,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0400,32'h7000_8030,32'h0C00_1000,12'h060},
    '{1'b1,12'h020,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_1000,2'b00,1'b0,1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,12'h020},
    '{1'b1,12'h140,1'b0,1'b0,12'h000,32'h4000_8000,32'h0C00_1000,2'b00,1'b0,1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,12'h140},
    '{1'b1,12'h160,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_2000,2'b00,1'b0,1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_2002,12'h160},
    '{1'b1,12'h160,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_2000,2'b01,1'b0,1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_2000,12'h160},
    '{1'b1,12'h180,1'b0,1'b0,12'h000,32'h0000_8030,32'h0C00_2000,2'b10,1'b0,1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1FFE,12'h180},
    '{1'b0,12'h000,1'b1,1'b1,12'h320,32'h0000_0030,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0600,32'h7000_0030,32'h0C00_1000,12'h320},
    '{1'b1,12'h0E0,1'b1,1'b1,12'h320,32'h0000_8030,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0100,32'h7000_8030,32'h0C00_1000,12'h0E0},
    '{1'b0,12'h000,1'b1,1'b0,12'h340,32'h0000_0030,32'h0C00_1000,2'b00,1'b0,1'b0,32'h0,32'h0,32'h0,12'h000},
    '{1'b1,12'h180,1'b0,1'b0,12'h000,32'h1000_0000,32'h0C00_1000,2'b00,1'b0,1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_1000,12'h000},
    '{1'b1,12'h1E0,1'b0,1'b0,12'h000,32'h1000_0000,32'h0C00_1000,2'b00,1'b0,1'b1,32'h8C00_0100,32'h7000_0000,32'h0C00_1000,12'h1E0},
    '{1'b0,12'h000,1'b1,1'b1,12'h400,32'h1000_0000,32'h0C00_1000,2'b00,1'b0,1'b0,32'h0,32'h0,32'h0,12'h000},
    '{1'b0,12'h000,1'b1,1'b1,12'h5A0,32'h1000_0000,32'h0C00_1000,2'b00,1'b1,1'b1,32'h8C00_0600,32'h7000_0000,32'h0C00_1000,12'h5A0},
    '{1'b1,12'h160,1'b0,1'b0,12'h000,32'h1000_8030,32'h0C00_3000,2'b00,1'b0,1'b1,32'hA000_0000,32'h7000_00F0,32'h0C00_3000,12'h000},
    '{1'b0,12'h000,1'b0,1'b0,12'h000,32'h0000_0030,32'h0C00_1000,2'b00,1'b0,1'b0,32'h0,32'h0,32'h0,12'h000}
  };
  localparam string TAG [N] = '{"R8","R8","R8","R7","R7","R9","R6","R6",
                                "R10","R1","R4","R2","R2","R3","R3","R2","R11"};

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [31:0] last_pc = 0;
  logic [11:0] exp_expevt = 0, exp_intevt = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    exc_valid_i = v.exc_v; exc_code_i = v.code; irq_pend_i = v.irq;
    irq_vec_valid_i = v.vval; irq_vec_i = v.vec; sr_i = v.sr; pc_i = v.pc;
    dslot_i = v.ds; sleep_i = v.slp; take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R11)
    check("R11 reset redirect", {31'd0, redirect_o}, 32'd0);
    check("R11 reset pc", pc_o, 32'd0);
    check("R11 reset sr", sr_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i]);
      check({TAG[i], " redirect"}, {31'd0, redirect_o}, {31'd0, TBL[i].redir});
      if (TBL[i].redir) begin
        last_pc = TBL[i].epc;
        if (TBL[i].exc_v) exp_expevt = TBL[i].evt; else exp_intevt = TBL[i].evt;
        check({TAG[i], " pc"}, pc_o, TBL[i].epc);
        check({TAG[i], " sr"}, sr_o, TBL[i].esr);
        check({TAG[i], " spc"}, spc_o, TBL[i].espc);
        check("R5 ssr", ssr_o, TBL[i].sr);
        check("R5 sgr", sgr_o, r15_i);
      end else begin
        check({TAG[i], " pc held"}, pc_o, last_pc);
      end
      check({TAG[i], " expevt"}, {20'd0, expevt_o}, {20'd0, exp_expevt});
      check({TAG[i], " intevt"}, {20'd0, intevt_o}, {20'd0, exp_intevt});
    end

    // R4 mask level follows status bits 7:4
    @(negedge clk);
    sr_i = 32'h0000_00A0;
    #1 check("R4 level", {28'd0, irq_level_o}, 32'hA);

    // R11 pending exception without take: no entry
    exc_valid_i = 1'b1; exc_code_i = 12'h180; sr_i = 32'h0; dslot_i = 2'b00;
    @(negedge clk);
    check("R11 no take", {31'd0, redirect_o}, 32'd0);
    check("R11 no take pc", pc_o, last_pc);

    // R11 pulse width and R6 / R3 strobes
    exc_valid_i = 1'b1; exc_code_i = 12'h180; dslot_i = 2'b01; pc_i = 32'h0C00_4000;
    take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
    check("R6 dslot clr", {31'd0, dslot_clr_o}, 32'd1);
    check("R3 sleep clr", {31'd0, sleep_clr_o}, 32'd1);
    check("R6 spc", spc_o, 32'h0C00_3FFE);
    @(negedge clk);
    check("R11 pulse end", {31'd0, redirect_o}, 32'd0);
    check("R6 clr end", {31'd0, dslot_clr_o}, 32'd0);

    // R10 interrupt leaves expevt alone
    exc_valid_i = 1'b0; irq_pend_i = 1'b1; irq_vec_valid_i = 1'b1; irq_vec_i = 12'h620;
    dslot_i = 2'b00; take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0; irq_pend_i = 1'b0;
    check("R10 intevt", {20'd0, intevt_o}, 32'h620);
    check("R10 expevt kept", {20'd0, expevt_o}, 32'h180);
    check("R10 pc", pc_o, 32'h8C00_0600);
    check("R6 no slot clr", {31'd0, dslot_clr_o}, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule